// File: doc/BRIEF.md
# Per-Rank On-Die-Termination Controller

This block drives one on-die-termination (ODT) line per chip select of a DDR2-style memory controller. Every chip select carries two 3-bit termination policies, one applied to reads and one to writes. When the scheduler issues a command, the block reads, for each line, the policy that matches the command direction. That policy decides whether the line terminates for the targeted chip select. A policy can select the rank itself, every other rank, the ranks of the other module, or every rank. Chip selects 0 and 1 share one module and chip selects 2 and 3 share the other.

The lines that a command selects go high after a programmable delay. They then stay high for a programmable number of cycles, normally 4. Commands can arrive close together. In that case the block does not restart the window: it merges the requests. It holds the union of the selected lines from the earlier start to the later end. A configuration error output warns when a direction has a nonzero policy and that direction's total latency is below 3 cycles.

Top module: `odt_policy_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all ODT lines and `cfg_err` are low.
- R2: Line i's policy sits in bits [3i+2:3i] of its policy bus. Code 001 asserts line i only when the target chip select is i. Code 010 asserts line i only when the target is any chip select other than i.
- R3: Code 011 asserts line i only when the target lies in the other module. The modules are {0,1} and {2,3}. Code 100 asserts line i for every target. Code 000 never asserts it.
- R4: Codes 101, 110 and 111 act exactly like 000.
- R5: A read command (`cmd_is_wr`=0) decodes `rd_policy`. A write command (`cmd_is_wr`=1) decodes `wr_policy`.
- R6: Take a command sampled at clock edge k, with delay D and window W. Its selected lines are high after edges k+D through k+D+W-1, which is W cycles. When W=0 the command asserts nothing.
- R7: A command can arrive while an earlier window is pending or active. The block then drives the OR of both patterns, from the earlier start until the later end.
- R8: A command whose decoded pattern is all zero leaves any window in progress unchanged.
- R9: `cfg_err` is registered and goes high one cycle after either of two conditions. One is any nonzero read code while `rd_latency` is below 3. The other is any nonzero write code while `wr_latency` is below 3. In every other case `cfg_err` is low one cycle later. A latency of exactly 3 raises no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A read or write command is issued this cycle |
| cmd_is_wr | input | 1 | 1 = write, 0 = read |
| cmd_cs | input | 2 | Target chip select |
| rd_policy | input | 12 | Read termination codes, 3 bits per chip select |
| wr_policy | input | 12 | Write termination codes, 3 bits per chip select |
| rd_latency | input | 4 | CAS plus additive latency, in cycles |
| wr_latency | input | 4 | Write plus additive latency, in cycles |
| odt_delay | input | 4 | Cycles from command to first asserted cycle |
| odt_window | input | 4 | Number of asserted cycles per command |
| odt_out | output | 4 | ODT lines, bit i for chip select i |
| cfg_err | output | 1 | Latency too short for an enabled policy |

## Verification
Two activities can fall in the same clock edge: a new command is captured, and an earlier window counts down or reaches its final cycle. The bench issues a second command on the edge right after the first. It then watches the lines cycle by cycle. It expects the union pattern from the first start to the second end, and all lines low exactly one cycle later. The bench also issues a command that selects no lines while a window is in progress. The running window must end on its original cycle, neither cut short nor extended.

// File: rtl/odt_pkg.sv
package odt_pkg;

    localparam logic [2:0] POL_NONE   = 3'd0;
    localparam logic [2:0] POL_SELF   = 3'd1;
    localparam logic [2:0] POL_OTHERS = 3'd2;
    localparam logic [2:0] POL_XMOD   = 3'd3;
    localparam logic [2:0] POL_ALL    = 3'd4;

    localparam int MIN_LAT = 3;

    // Decide whether one line terminates for a given target.
    function automatic logic pol_hit(input logic [2:0] code, input int line,
                                     input int tgt, input int per_mod);
        logic hit;
        case (code)
            POL_SELF:   hit = (line == tgt);
            POL_OTHERS: hit = (line != tgt);
            POL_XMOD:   hit = ((line / per_mod) != (tgt / per_mod));
            POL_ALL:    hit = 1'b1;
            default:    hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/odt_pol_decode.sv
module odt_pol_decode #(
    parameter int NUM_CS  = 4,
    parameter int PER_MOD = 2
) (
    input  logic                      cmd_is_wr,
    input  logic [$clog2(NUM_CS)-1:0] cmd_cs,
    input  logic [3*NUM_CS-1:0]       rd_policy,
    input  logic [3*NUM_CS-1:0]       wr_policy,
    output logic [NUM_CS-1:0]         hit_pat
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic [2:0] code;
        assign code       = cmd_is_wr ? wr_policy[3*i +: 3] : rd_policy[3*i +: 3];
        assign hit_pat[i] = odt_pkg::pol_hit(code, i, int'(cmd_cs), PER_MOD);
    end
endmodule

// File: rtl/odt_cfg_check.sv
module odt_cfg_check #(
    parameter int NUM_CS = 4,
    parameter int LAT_W  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3*NUM_CS-1:0]   rd_policy,
    input  logic [3*NUM_CS-1:0]   wr_policy,
    input  logic [LAT_W-1:0]      rd_latency,
    input  logic [LAT_W-1:0]      wr_latency,
    output logic                  cfg_err
);
    logic err_d, err_q;
    logic rd_short, wr_short;

    always_comb begin
        rd_short = (rd_latency < LAT_W'(odt_pkg::MIN_LAT));
        wr_short = (wr_latency < LAT_W'(odt_pkg::MIN_LAT));
        err_d    = 1'b0;
        for (int i = 0; i < NUM_CS; i++) begin
            if (rd_short && (rd_policy[3*i +: 3] != 3'd0)) err_d = 1'b1;
            if (wr_short && (wr_policy[3*i +: 3] != 3'd0)) err_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_d;
    end

    assign cfg_err = err_q;
endmodule

// File: rtl/odt_window_track.sv
module odt_window_track #(
    parameter int NUM_CS = 4,
    parameter int DLY_W  = 4,
    parameter int WIN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NUM_CS-1:0] new_pat,
    input  logic [DLY_W-1:0]  delay,
    input  logic [WIN_W-1:0]  window,
    output logic [NUM_CS-1:0] odt
);
    localparam int CNT_W = ((DLY_W > WIN_W) ? DLY_W : WIN_W) + 1;

    typedef struct packed {
        logic [CNT_W-1:0]  start;  // cycles until lines go high
        logic [CNT_W-1:0]  stop;   // cycles until lines go low
        logic [NUM_CS-1:0] pat;
    } trk_t;

    trk_t st_d, st_q;
    logic [CNT_W-1:0] start_dec, stop_dec, new_start, new_stop;

    always_comb begin
        start_dec = (st_q.start != '0) ? st_q.start - 1'b1 : '0;
        stop_dec  = (st_q.stop  != '0) ? st_q.stop  - 1'b1 : '0;
        new_start = CNT_W'(delay);
        new_stop  = CNT_W'(delay) + CNT_W'(window);
        st_d.start = start_dec;
        st_d.stop  = stop_dec;
        st_d.pat   = (stop_dec == '0) ? '0 : st_q.pat;
        if (load && (window != '0) && (new_pat != '0)) begin
            if (stop_dec == '0) begin
                st_d.start = new_start;
                st_d.stop  = new_stop;
                st_d.pat   = new_pat;
            end else begin
                st_d.start = (new_start < start_dec) ? new_start : start_dec;
                st_d.stop  = (new_stop  > stop_dec)  ? new_stop  : stop_dec;
                st_d.pat   = st_q.pat | new_pat;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign odt = ((st_q.stop != '0) && (st_q.start == '0)) ? st_q.pat : '0;
endmodule

// File: rtl/odt_policy_ctrl.sv
module odt_policy_ctrl #(
    parameter int NUM_CS  = 4,
    parameter int PER_MOD = 2,
    parameter int DLY_W   = 4,
    parameter int WIN_W   = 4,
    parameter int LAT_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic                      cmd_is_wr,
    input  logic [$clog2(NUM_CS)-1:0] cmd_cs,
    input  logic [3*NUM_CS-1:0]       rd_policy,
    input  logic [3*NUM_CS-1:0]       wr_policy,
    input  logic [LAT_W-1:0]          rd_latency,
    input  logic [LAT_W-1:0]          wr_latency,
    input  logic [DLY_W-1:0]          odt_delay,
    input  logic [WIN_W-1:0]          odt_window,
    output logic [NUM_CS-1:0]         odt_out,
    output logic                      cfg_err
);
    logic [NUM_CS-1:0] hit_pat;

    odt_pol_decode #(.NUM_CS(NUM_CS), .PER_MOD(PER_MOD)) u_decode (
        .cmd_is_wr (cmd_is_wr),
        .cmd_cs    (cmd_cs),
        .rd_policy (rd_policy),
        .wr_policy (wr_policy),
        .hit_pat   (hit_pat)
    );

    odt_window_track #(.NUM_CS(NUM_CS), .DLY_W(DLY_W), .WIN_W(WIN_W)) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cmd_valid),
        .new_pat (hit_pat),
        .delay   (odt_delay),
        .window  (odt_window),
        .odt     (odt_out)
    );

    odt_cfg_check #(.NUM_CS(NUM_CS), .LAT_W(LAT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_policy  (rd_policy),
        .wr_policy  (wr_policy),
        .rd_latency (rd_latency),
        .wr_latency (wr_latency),
        .cfg_err    (cfg_err)
    );
endmodule

// File: rtl/odt_policy_ctrl_chk.sv
module odt_policy_ctrl_chk #(
    parameter int NUM_CS = 4,
    parameter int DLY_W  = 4,
    parameter int WIN_W  = 4,
    parameter int LAT_W  = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic                      cmd_is_wr,
    input logic [$clog2(NUM_CS)-1:0] cmd_cs,
    input logic [3*NUM_CS-1:0]       rd_policy,
    input logic [3*NUM_CS-1:0]       wr_policy,
    input logic [LAT_W-1:0]          rd_latency,
    input logic [LAT_W-1:0]          wr_latency,
    input logic [DLY_W-1:0]          odt_delay,
    input logic [WIN_W-1:0]          odt_window,
    input logic [NUM_CS-1:0]         odt_out,
    input logic                      cfg_err,
    input logic [NUM_CS-1:0]         hit_pat
);
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (odt_out == '0 && !cfg_err));

    a_r6_prompt_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && odt_delay == '0 && odt_window != '0)
        |=> ((odt_out & $past(hit_pat)) == $past(hit_pat)));

    a_r9_cfg_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latency >= LAT_W'(3) && wr_latency >= LAT_W'(3)) |=> !cfg_err);

    a_r9_cfg_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latency < LAT_W'(3) && rd_policy != '0) |=> cfg_err);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        logic [2:0] code;
        assign code = cmd_is_wr ? wr_policy[3*i +: 3] : rd_policy[3*i +: 3];

        a_r2_self_only: assert property (@(posedge clk) disable iff (!rst_n)
            (code == 3'd1 && hit_pat[i]) |-> (int'(cmd_cs) == i));

        a_r4_reserved_off: assert property (@(posedge clk) disable iff (!rst_n)
            (code >= 3'd5) |-> !hit_pat[i]);
    end
endmodule

bind odt_policy_ctrl odt_policy_ctrl_chk #(
    .NUM_CS(NUM_CS), .DLY_W(DLY_W), .WIN_W(WIN_W), .LAT_W(LAT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_is_wr  (cmd_is_wr),
    .cmd_cs     (cmd_cs),
    .rd_policy  (rd_policy),
    .wr_policy  (wr_policy),
    .rd_latency (rd_latency),
    .wr_latency (wr_latency),
    .odt_delay  (odt_delay),
    .odt_window (odt_window),
    .odt_out    (odt_out),
    .cfg_err    (cfg_err),
    .hit_pat    (hit_pat)
);

// File: tb/odt_policy_ctrl_bench.sv
module odt_policy_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_is_wr = 1'b0;
    logic [1:0]  cmd_cs = '0;
    logic [11:0] rd_policy = '0;
    logic [11:0] wr_policy = '0;
    logic [3:0]  rd_latency = 4'd5;
    logic [3:0]  wr_latency = 4'd5;
    logic [3:0]  odt_delay = '0;
    logic [3:0]  odt_window = 4'd4;
    logic [3:0]  odt_out;
    logic        cfg_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    odt_policy_ctrl u_odt_policy_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
        .cmd_cs(cmd_cs), .rd_policy(rd_policy), .wr_policy(wr_policy),
        .rd_latency(rd_latency), .wr_latency(wr_latency), .odt_delay(odt_delay),
        .odt_window(odt_window), .odt_out(odt_out), .cfg_err(cfg_err)
    );

    function automatic logic [11:0] all4(input logic [2:0] c);
        return {c, c, c, c};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Issue one command; returns at the first negedge after capture (j=0).
    task automatic issue(input logic wr, input logic [1:0] cs);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_is_wr = wr; cmd_cs = cs;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 odt", odt_out, 4'b0000);
        chk("R1 cfg_err", {3'b0, cfg_err}, 4'b0000);
    endtask

    task automatic t_codes;
        logic [3:0] exp;
        odt_delay = 4'd0; odt_window = 4'd1;
        for (int c = 0; c < 8; c++) begin
            rd_policy = all4(3'(c));
            case (c)
                1: exp = 4'b0010;
                2: exp = 4'b1101;
                3: exp = 4'b1100;
                4: exp = 4'b1111;
                default: exp = 4'b0000;
            endcase
            issue(1'b0, 2'd1);
            if (c >= 5)      chk("R4 reserved code", odt_out, exp);
            else if (c == 1 || c == 2) chk("R2 self/others", odt_out, exp);
            else             chk("R3 module/all/none", odt_out, exp);
            idle(2);
        end
        rd_policy = all4(3'd3);
        issue(1'b0, 2'd2);
        chk("R3 other module of cs2", odt_out, 4'b0011);
        idle(2);
        rd_policy = {3'd4, 3'd3, 3'd2, 3'd1};
        issue(1'b0, 2'd0);
        chk("R2 per-line fields cs0", odt_out, 4'b1111);
        idle(2);
        issue(1'b0, 2'd3);
        chk("R2 per-line fields cs3", odt_out, 4'b1010);
        idle(2);
    endtask

    task automatic t_direction;
        odt_delay = 4'd0; odt_window = 4'd1;
        rd_policy = all4(3'd4); wr_policy = all4(3'd1);
        issue(1'b1, 2'd2);
        chk("R5 write uses wr_policy", odt_out, 4'b0100);
        idle(2);
        issue(1'b0, 2'd2);
        chk("R5 read uses rd_policy", odt_out, 4'b1111);
        idle(2);
    endtask

    task automatic t_timing;
        rd_policy = all4(3'd1);
        odt_delay = 4'd2; odt_window = 4'd3;
        issue(1'b0, 2'd3);
        for (int j = 0; j < 7; j++) begin
            chk("R6 delay/window", odt_out, (j >= 2 && j <= 4) ? 4'b1000 : 4'b0000);
            @(negedge clk);
        end
        odt_delay = 4'd0; odt_window = 4'd0;
        issue(1'b0, 2'd0);
        for (int j = 0; j < 4; j++) begin
            chk("R6 zero window", odt_out, 4'b0000);
            @(negedge clk);
        end
    endtask

    task automatic t_merge;
        rd_policy = all4(3'd1);
        odt_delay = 4'd0; odt_window = 4'd4;
        issue(1'b0, 2'd0);
        chk("R7 first alone", odt_out, 4'b0001);
        cmd_valid = 1'b1; cmd_cs = 2'd3;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int j = 0; j < 4; j++) begin
            chk("R7 merged union", odt_out, 4'b1001);
            @(negedge clk);
        end
        chk("R7 end after later window", odt_out, 4'b0000);
        idle(2);
    endtask

    task automatic t_null_cmd;
        rd_policy = all4(3'd1);
        odt_delay = 4'd0; odt_window = 4'd4;
        issue(1'b0, 2'd0);
        rd_policy = all4(3'd0);
        cmd_valid = 1'b1; cmd_cs = 2'd1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int j = 1; j < 4; j++) begin
            chk("R8 window kept", odt_out, 4'b0001);
            @(negedge clk);
        end
        chk("R8 not extended", odt_out, 4'b0000);
        idle(2);
    endtask

    task automatic t_cfg;
        rd_policy = '0; wr_policy = '0;
        rd_latency = 4'd2; wr_latency = 4'd2;
        idle(2);
        chk("R9 zero policies ok", {3'b0, cfg_err}, 4'b0000);
        rd_policy = 12'b001;
        idle(1);
        chk("R9 read latency short", {3'b0, cfg_err}, 4'b0001);
        rd_latency = 4'd3;
        idle(1);
        chk("R9 read latency 3 ok", {3'b0, cfg_err}, 4'b0000);
        wr_policy = 12'b100_000_000_000;
        idle(1);
        chk("R9 write latency short", {3'b0, cfg_err}, 4'b0001);
        wr_latency = 4'd3;
        idle(1);
        chk("R9 write latency 3 ok", {3'b0, cfg_err}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_codes();
        t_direction();
        t_timing();
        t_merge();
        t_null_cmd();
        t_cfg();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule